// File: doc/BRIEF.md
# Interval Tick Timer with Missed-Tick Recovery

This block keeps a free-running cycle counter and a narrower compare register. When the low bits of the counter match the compare value, a sticky pending flag is set. The flag drives a maskable interrupt line. Reset loads the compare register and the stored expected-tick value with the default period, which is the counter (zero at reset) plus one period. The `arm` pulse later reloads both with the current counter plus the programmed period.

When the interrupt is serviced, a `svc_start` pulse starts a rescheduling engine. The engine takes the current counter value and measures how far it has run past the stored expected tick. From that distance it works out the number of elapsed periods and the remainder. If the distance is short, it uses a cheap repeated-subtraction loop. If it is long, it uses a multi-cycle restoring divider. It then stores the next expected tick on the period grid and programs the compare register. When the next compare point would be too close, the engine pushes the compare point one extra period further out. The stored expected tick is not moved in that case. The engine also reports the elapsed-tick count and a late flag.

The engine state machine has five states:
- `ST_IDLE` waits for a request. The transition `arm` stays in `ST_IDLE`, and the transition `start` goes to `ST_PICK`.
- `ST_PICK` chooses the path. The transition `cheap` goes to `ST_SUB`, and the transition `long` goes to `ST_DIV` and launches the divider.
- `ST_SUB` subtracts one period per cycle. The transition `sub_more` stays in `ST_SUB`, and `sub_end` goes to `ST_ADJ`.
- `ST_DIV` waits for the divider. The transition `div_end` goes to `ST_ADJ`.
- `ST_ADJ` writes the results. The transition `finish` returns to `ST_IDLE` and pulses `done_o`.

Top module: `interval_tick_timer`

## Requirements
- R1: After reset the counter reads 0 and then increases by exactly 1 every clock. While reset is held, `expect_o` and `compare_o` both equal `DEF_PERIOD`, `pend_o` is 0 and `busy_o` is 0.
- R2: `pend_o` becomes 1 in the cycle after the cycle in which `counter_o[CMP_W-1:0]` equals `compare_o`. It stays 1 until an `irq_clr` pulse, which clears it on the next edge. If a match and a clear happen in the same cycle, the match wins.
- R3: `irq_o` is 1 only when `pend_o` is 1 and `irq_mask` is 0. Changing `irq_mask` does not change `pend_o`.
- R4: An `arm` pulse while the engine is idle sets `expect_o` to counter + period. It also sets `compare_o` to the low `CMP_W` bits of that value, on the next edge. `arm` takes priority over `svc_start` in the same cycle.
- R5: A period write whose data is zero is ignored. A nonzero write becomes the period used by the next `arm` or service.
- R6: On service, the engine computes elapsed = now − expected tick, modulo 2^CNT_W, where now is the counter value in the cycle `svc_start` is sampled. If (elapsed >> 5) < period, it uses the cheap path: ticks start at 1, and the remainder starts at elapsed. While the remainder is greater than the period, the engine subtracts one period from the remainder and adds one tick.
- R7: Otherwise the engine uses the divider path: ticks = 1 + elapsed / period and remainder = elapsed mod period.
- R8: On completion, `expect_o` = now + (period − remainder), and `ticks_o` holds the tick count.
- R9: On completion, `compare_o` equals the low `CMP_W` bits of the new expected tick. If (period − remainder) < 2^NEAR_SHIFT, one extra period is added to `compare_o` only.
- R10: On completion, `late_o` is 1 exactly when the tick count is greater than `LATE_TICKS`.
- R11: `busy_o` is 1 from the cycle after an accepted `svc_start` until the cycle in which `done_o` pulses for one cycle. `svc_start` and `arm` have no effect while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_we | input | 1 | Period write strobe |
| period_wdata | input | PER_W | New period in cycles (zero ignored) |
| arm | input | 1 | Realign expected tick and compare to counter + period |
| svc_start | input | 1 | Start the rescheduling engine |
| irq_mask | input | 1 | 1 masks the interrupt line |
| irq_clr | input | 1 | Write-one-to-clear of the pending flag |
| counter_o | output | CNT_W | Free-running cycle counter |
| compare_o | output | CMP_W | Current compare value |
| pend_o | output | 1 | Sticky interrupt pending flag |
| irq_o | output | 1 | Masked interrupt request |
| busy_o | output | 1 | Engine is working |
| done_o | output | 1 | One-cycle completion pulse |
| ticks_o | output | CNT_W | Elapsed periods from the last service |
| late_o | output | 1 | Tick count exceeded LATE_TICKS |
| expect_o | output | CNT_W | Stored expected-tick value |

## Verification
The bench goes after the cases where the elapsed distance is an exact multiple of the period. There the cheap path leaves a full-period remainder, so the next expected tick equals now, while the divider path leaves a zero remainder. A design that mixes the two up reports a tick count off by one and an expected tick a period away. The sweep crosses the threshold between the two paths at 32 periods minus one and at exactly 32 periods, and it crosses the late boundary at eight and nine periods. It uses a period below the near-skip threshold, so a design that moved the stored expected tick together with the skipped compare point, or forgot the skip, shows a wrong compare or expected value. It also checks the following:
- A zero period write is ignored.
- Pending stays set until cleared, and the interrupt is masked without losing pending.
- A second start or arm pulse during a busy service leaves the result untouched.

// File: rtl/itmr_pkg.sv
`timescale 1ns/1ps
package itmr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_SUB,
        ST_DIV,
        ST_ADJ
    } svc_state_t;

    // Right shift used to pick the cheap subtraction path.
    localparam int CHEAP_SHIFT = 5;

endpackage

// File: rtl/itmr_counter.sv
`timescale 1ns/1ps
module itmr_counter #(
    parameter int CNT_W      = 64,
    parameter int CMP_W      = 32,
    parameter int DEF_PERIOD = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_we,
    input  logic [CMP_W-1:0] cmp_val,
    input  logic             irq_clr,
    input  logic             irq_mask,
    output logic [CNT_W-1:0] cnt,
    output logic [CMP_W-1:0] cmp,
    output logic             pend,
    output logic             irq
);

    localparam logic [CMP_W-1:0] CMP_RST = CMP_W'(DEF_PERIOD);

    logic [CNT_W-1:0] cnt_q;
    logic [CMP_W-1:0] cmp_q;
    logic             pend_q;
    logic             hit;

    // Low slice of the counter against the compare register.
    assign hit = (cnt_q[CMP_W-1:0] == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= CMP_RST;
        end else if (cmp_we) begin
            cmp_q <= cmp_val;
        end
    end

    // Sticky pending; a match outranks a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end else if (irq_clr) begin
            pend_q <= 1'b0;
        end
    end

    assign cnt  = cnt_q;
    assign cmp  = cmp_q;
    assign pend = pend_q;
    assign irq  = pend_q & ~irq_mask;

endmodule

// File: rtl/itmr_divider.sv
`timescale 1ns/1ps
module itmr_divider #(
    parameter int N = 64,
    parameter int D = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [D-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] quot,
    output logic [D-1:0] rem
);

    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] STEPS = CW'(N);

    logic [N-1:0]  q_q;
    logic [D-1:0]  r_q;
    logic [D-1:0]  d_q;
    logic [CW-1:0] left_q;
    logic          busy_q;
    logic          done_q;

    logic [D:0]    shifted;
    logic [D:0]    diff;
    logic          ge;

    // One restoring step: bring in the next dividend bit, try the subtract.
    assign shifted = {r_q, q_q[N-1]};
    assign diff    = shifted - {1'b0, d_q};
    assign ge      = (shifted >= {1'b0, d_q});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q    <= '0;
            r_q    <= '0;
            d_q    <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                q_q    <= dividend;
                r_q    <= '0;
                d_q    <= divisor;
                left_q <= STEPS;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                q_q    <= {q_q[N-2:0], ge};
                r_q    <= ge ? diff[D-1:0] : shifted[D-1:0];
                left_q <= left_q - 1'b1;
                if (left_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign quot = q_q;
    assign rem  = r_q;

endmodule

// File: rtl/itmr_engine.sv
`timescale 1ns/1ps
module itmr_engine
    import itmr_pkg::*;
#(
    parameter int CNT_W      = 64,
    parameter int CMP_W      = 32,
    parameter int PER_W      = 32,
    parameter int DEF_PERIOD = 1000,
    parameter int LATE_TICKS = 1000,
    parameter int NEAR_SHIFT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_we,
    input  logic [PER_W-1:0] period_wdata,
    input  logic             arm,
    input  logic             svc_start,
    input  logic [CNT_W-1:0] cnt,
    output logic             cmp_we,
    output logic [CMP_W-1:0] cmp_val,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] ticks,
    output logic             late,
    output logic [CNT_W-1:0] expect_tick
);

    localparam logic [PER_W-1:0] PER_RST  = PER_W'(DEF_PERIOD);
    localparam logic [CNT_W-1:0] EXP_RST  = CNT_W'(DEF_PERIOD);
    localparam logic [CNT_W-1:0] NEAR_LIM = CNT_W'(1) << NEAR_SHIFT;
    localparam logic [CNT_W-1:0] LATE_LIM = CNT_W'(LATE_TICKS);

    svc_state_t state_q, state_d;

    logic [PER_W-1:0] period_q;
    logic [PER_W-1:0] per_s_q;
    logic [CNT_W-1:0] now_q;
    logic [CNT_W-1:0] rem_q;
    logic [CNT_W-1:0] ticks_q;
    logic [CNT_W-1:0] expect_q;
    logic             late_q;
    logic             done_q;

    logic [CNT_W-1:0] per_ext;
    logic [CNT_W-1:0] conv;
    logic [CNT_W-1:0] new_exp;
    logic [CNT_W-1:0] skip_add;
    logic [CNT_W-1:0] arm_val;
    logic             take_cheap;
    logic             sub_again;

    logic             div_start;
    logic             div_busy;
    logic             div_done;
    logic [CNT_W-1:0] div_quot;
    logic [PER_W-1:0] div_rem;

    assign per_ext    = CNT_W'(per_s_q);
    assign take_cheap = ((rem_q >> CHEAP_SHIFT) < per_ext);
    assign sub_again  = (rem_q > per_ext);
    assign conv       = per_ext - rem_q;
    assign new_exp    = now_q + conv;
    assign skip_add   = (conv < NEAR_LIM) ? per_ext : '0;
    assign arm_val    = cnt + CNT_W'(period_q);

    itmr_divider #(
        .N (CNT_W),
        .D (PER_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (rem_q),
        .divisor  (per_s_q),
        .busy     (div_busy),
        .done     (div_done),
        .quot     (div_quot),
        .rem      (div_rem)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!arm && svc_start) begin
                    state_d = ST_PICK;
                end
            end
            ST_PICK: state_d = take_cheap ? ST_SUB : ST_DIV;
            ST_SUB:  state_d = sub_again ? ST_SUB : ST_ADJ;
            ST_DIV:  state_d = div_done ? ST_ADJ : ST_DIV;
            ST_ADJ:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Combinational outputs toward the counter and divider
    always_comb begin
        cmp_we    = 1'b0;
        cmp_val   = '0;
        div_start = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) begin
                    cmp_we  = 1'b1;
                    cmp_val = arm_val[CMP_W-1:0];
                end
            end
            ST_PICK: div_start = !take_cheap && !div_busy;
            ST_ADJ: begin
                cmp_we  = 1'b1;
                cmp_val = CMP_W'(new_exp + skip_add);
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= PER_RST;
            per_s_q  <= PER_RST;
            now_q    <= '0;
            rem_q    <= '0;
            ticks_q  <= '0;
            expect_q <= EXP_RST;
            late_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (period_we && (period_wdata != '0)) begin
                period_q <= period_wdata;
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (arm) begin
                        expect_q <= arm_val;
                    end else if (svc_start) begin
                        now_q   <= cnt;
                        rem_q   <= cnt - expect_q;
                        per_s_q <= period_q;
                        ticks_q <= CNT_W'(1);
                    end
                end
                ST_SUB: begin
                    if (sub_again) begin
                        rem_q   <= rem_q - per_ext;
                        ticks_q <= ticks_q + 1'b1;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        ticks_q <= div_quot + 1'b1;
                        rem_q   <= CNT_W'(div_rem);
                    end
                end
                ST_ADJ: begin
                    expect_q <= new_exp;
                    late_q   <= (ticks_q > LATE_LIM);
                    done_q   <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign ticks       = ticks_q;
    assign late        = late_q;
    assign expect_tick = expect_q;

endmodule

// File: rtl/interval_tick_timer.sv
`timescale 1ns/1ps
module interval_tick_timer #(
    parameter int CNT_W      = 64,
    parameter int CMP_W      = 32,
    parameter int PER_W      = 32,
    parameter int DEF_PERIOD = 1000,
    parameter int LATE_TICKS = 1000,
    parameter int NEAR_SHIFT = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_we,
    input  logic [PER_W-1:0] period_wdata,
    input  logic             arm,
    input  logic             svc_start,
    input  logic             irq_mask,
    input  logic             irq_clr,
    output logic [CNT_W-1:0] counter_o,
    output logic [CMP_W-1:0] compare_o,
    output logic             pend_o,
    output logic             irq_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] ticks_o,
    output logic             late_o,
    output logic [CNT_W-1:0] expect_o
);

    logic             cmp_we;
    logic [CMP_W-1:0] cmp_val;

    itmr_counter #(
        .CNT_W      (CNT_W),
        .CMP_W      (CMP_W),
        .DEF_PERIOD (DEF_PERIOD)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_we   (cmp_we),
        .cmp_val  (cmp_val),
        .irq_clr  (irq_clr),
        .irq_mask (irq_mask),
        .cnt      (counter_o),
        .cmp      (compare_o),
        .pend     (pend_o),
        .irq      (irq_o)
    );

    itmr_engine #(
        .CNT_W      (CNT_W),
        .CMP_W      (CMP_W),
        .PER_W      (PER_W),
        .DEF_PERIOD (DEF_PERIOD),
        .LATE_TICKS (LATE_TICKS),
        .NEAR_SHIFT (NEAR_SHIFT)
    ) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_we    (period_we),
        .period_wdata (period_wdata),
        .arm          (arm),
        .svc_start    (svc_start),
        .cnt          (counter_o),
        .cmp_we       (cmp_we),
        .cmp_val      (cmp_val),
        .busy         (busy_o),
        .done         (done_o),
        .ticks        (ticks_o),
        .late         (late_o),
        .expect_tick  (expect_o)
    );

endmodule

// File: rtl/interval_tick_timer_chk.sv
`timescale 1ns/1ps
module interval_tick_timer_chk #(
    parameter int CNT_W = 64,
    parameter int CMP_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             svc_start,
    input logic             irq_mask,
    input logic             irq_clr,
    input logic [CNT_W-1:0] counter_o,
    input logic [CMP_W-1:0] compare_o,
    input logic             pend_o,
    input logic             irq_o,
    input logic             busy_o,
    input logic             done_o,
    input logic [CNT_W-1:0] expect_o
);

    // R1
    counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (counter_o == $past(counter_o) + 1'b1));

    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (counter_o[CMP_W-1:0] == compare_o) |=> pend_o);

    // R2
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !irq_clr) |=> pend_o);

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_o && !irq_mask));

    // R11
    busy_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_start && !arm && !busy_o) |=> busy_o);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R4 and R8
    expect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$past(arm && !busy_o)) |-> $stable(expect_o));

endmodule

bind interval_tick_timer interval_tick_timer_chk #(
    .CNT_W (CNT_W),
    .CMP_W (CMP_W)
) chk_i (.*);

// File: tb/interval_tick_timer_test.sv
`timescale 1ns/1ps
module interval_tick_timer_test;

    localparam int CW   = 16;
    localparam int MW   = 12;
    localparam int PW   = 12;
    localparam int DEFP = 20;
    localparam int LT   = 8;
    localparam int NS   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          period_we = 1'b0;
    logic [PW-1:0] period_wdata = '0;
    logic          arm = 1'b0;
    logic          svc_start = 1'b0;
    logic          irq_mask = 1'b0;
    logic          irq_clr = 1'b0;
    logic [CW-1:0] counter_o;
    logic [MW-1:0] compare_o;
    logic          pend_o, irq_o, busy_o, done_o, late_o;
    logic [CW-1:0] ticks_o;
    logic [CW-1:0] expect_o;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    logic [CW-1:0] m_exp = CW'(DEFP);
    logic [CW-1:0] m_per = CW'(DEFP);

    always #2.5 clk = ~clk;

    interval_tick_timer #(
        .CNT_W (CW), .CMP_W (MW), .PER_W (PW),
        .DEF_PERIOD (DEFP), .LATE_TICKS (LT), .NEAR_SHIFT (NS)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .period_we (period_we), .period_wdata (period_wdata),
        .arm (arm), .svc_start (svc_start),
        .irq_mask (irq_mask), .irq_clr (irq_clr),
        .counter_o (counter_o), .compare_o (compare_o),
        .pend_o (pend_o), .irq_o (irq_o),
        .busy_o (busy_o), .done_o (done_o),
        .ticks_o (ticks_o), .late_o (late_o), .expect_o (expect_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_period(input logic [PW-1:0] v);
        period_wdata = v;
        period_we    = 1'b1;
        @(negedge clk);
        period_we    = 1'b0;
        if (v != '0) m_per = CW'(v);
    endtask

    task automatic do_arm(input string req);
        logic [CW-1:0] c;
        c   = counter_o;
        arm = 1'b1;
        @(negedge clk);
        arm   = 1'b0;
        m_exp = c + m_per;
        chk(expect_o == m_exp, req, expect_o, m_exp);
        chk(compare_o == m_exp[MW-1:0], req, compare_o, m_exp[MW-1:0]);
    endtask

    task automatic service(input logic [CW-1:0] e, input bit poke);
        logic [CW-1:0] tgt, now, el, rem, t, conv, nexp;
        logic [MW-1:0] cmpv;
        bit            cheap;
        int            guard;
        tgt = m_exp + e;
        while (counter_o != tgt) @(negedge clk);
        now       = counter_o;
        svc_start = 1'b1;
        @(negedge clk);
        svc_start = 1'b0;
        if (poke) begin
            chk(busy_o == 1'b1, "R11 busy after start", busy_o, 1);
            arm       = 1'b1;
            svc_start = 1'b1;
            @(negedge clk);
            arm       = 1'b0;
            svc_start = 1'b0;
        end
        guard = 0;
        while (!done_o && guard < 4000) begin
            @(negedge clk);
            guard++;
        end
        chk(done_o == 1'b1, "R11 done pulse", done_o, 1);
        // Model of the rescheduling arithmetic
        el    = now - m_exp;
        cheap = ((el >> 5) < m_per);
        if (cheap) begin
            rem = el;
            t   = 1;
            while (rem > m_per) begin
                rem = rem - m_per;
                t   = t + 1;
            end
        end else begin
            t   = 1 + el / m_per;
            rem = el % m_per;
        end
        conv = m_per - rem;
        nexp = now + conv;
        cmpv = MW'(nexp + ((conv < CW'(1 << NS)) ? m_per : '0));
        if (cheap) chk(ticks_o == t, "R6 cheap ticks", ticks_o, t);
        else       chk(ticks_o == t, "R7 divide ticks", ticks_o, t);
        chk(expect_o == nexp, "R8 expected tick", expect_o, nexp);
        chk(compare_o == cmpv, "R9 compare", compare_o, cmpv);
        chk(late_o == (t > LT), "R10 late", late_o, (t > LT));
        m_exp = nexp;
        @(negedge clk);
        chk(busy_o == 1'b0, "R11 idle after done", busy_o, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] a;
        int plist [5] = '{20, 37, 64, 100, 9};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(counter_o == 0, "R1 reset counter", counter_o, 0);
        chk(expect_o == DEFP, "R1 reset expect", expect_o, DEFP);
        chk(compare_o == DEFP, "R1 reset compare", compare_o, DEFP);
        chk(pend_o == 0, "R1 reset pending", pend_o, 0);
        chk(busy_o == 0, "R1 reset busy", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        a = counter_o;
        repeat (7) @(negedge clk);
        chk(counter_o - a == 7, "R1 step", counter_o - a, 7);

        // R2 pending set timing and stickiness
        while (!pend_o) @(negedge clk);
        chk(counter_o[MW-1:0] == compare_o + 1'b1, "R2 set cycle", counter_o[MW-1:0], compare_o + 1'b1);
        repeat (3) @(negedge clk);
        chk(pend_o == 1'b1, "R2 sticky", pend_o, 1);

        // R3 masking
        irq_mask = 1'b1;
        #1;
        chk(irq_o == 1'b0, "R3 masked irq", irq_o, 0);
        @(negedge clk);
        chk(pend_o == 1'b1, "R3 mask keeps pending", pend_o, 1);
        irq_mask = 1'b0;
        #1;
        chk(irq_o == 1'b1, "R3 unmasked irq", irq_o, 1);
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(pend_o == 1'b0, "R2 clear", pend_o, 0);

        // R5 zero period ignored, nonzero used
        set_period('0);
        do_arm("R5 zero write ignored");
        set_period(PW'(37));
        do_arm("R5 new period");

        // Sweep of periods and service distances
        foreach (plist[i]) begin
            logic [CW-1:0] p;
            logic [CW-1:0] elist [11];
            p = CW'(plist[i]);
            set_period(PW'(p));
            elist = '{0, 1, p - 1, p, p + 1, 3 * p, 8 * p, 9 * p,
                      32 * p - 1, 32 * p, 32 * p + p / 2};
            foreach (elist[j]) begin
                do_arm("R4 arm");
                service(elist[j], (j == 3));
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule